// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures a downstream FPGA over a one-bit serial link. The block generates the link clock itself. It pulls bitstream bytes from a valid/ready byte source and drives them one bit per configuration clock on a single data line. It starts each run with a reset handshake: the target's program line is pulsed low for a fixed number of system cycles, and then the block waits for the target's init line to go high.

The target's done line is not treated as the end of the job. Every bitstream bit is always delivered. Clocking then continues with the data line held at logic one until done is seen high. After that, a fixed run of extra clocks is issued, so the target's start-up sequence completes even when done rises early. Two timeouts guard the run. One applies while waiting for init, and one applies while padding for done. The outcome is reported on three sticky flags, which hold until the next start.

The configuration clock is the system clock divided by an even ratio, and it idles low. Data changes only while the clock is low, so the data is steady at every rising edge, where the target samples it.

Top module: `serial_cfg_loader`

## Requirements
- R1: After a synchronous reset, busy, cfg_ok, err_init, err_done, src_ready and cfg_clk are low, tgt_prog_n is high and cfg_dout is high.
- R2: A start pulse drives tgt_prog_n low for exactly PROG_CYCLES system cycles. The block then waits for tgt_init high. If tgt_init stays low for INIT_LIMIT cycles, err_init is raised, busy drops and no configuration clock edge is produced.
- R3: While running, each high phase of cfg_clk lasts CLK_DIV/2 system cycles. Outside the shift, pad and post-done phases, cfg_clk is held low.
- R4: Bytes are sent most significant bit first, one bit per rising edge of cfg_clk. cfg_dout never changes while cfg_clk is high or in the cycle in which it rises.
- R5: src_ready is high only while the shifter is empty and cfg_clk is low. A byte is taken when src_valid and src_ready are both high, and src_last marks the final byte. While no byte is offered, the clock pauses low.
- R6: A high level on tgt_done during data delivery has no effect. All 8×N data bits are still clocked out.
- R7: After the last data bit, cfg_dout is 1 at every padding rising edge until tgt_done is seen high.
- R8: Once tgt_done is seen high after the data, exactly EXTRA_CLKS (default 8) further rising edges are issued. After the falling edge that follows the last of them, cfg_ok rises and the clock stays low.
- R9: If PAD_LIMIT padding rising edges pass without tgt_done, err_done is raised after the next falling edge and clocking stops.
- R10: busy is high from the cycle after start until a flag is raised. No flag is high while busy. A start during a run is ignored, and a start after a finished run begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| src_data | input | 8 | Bitstream byte from the source |
| src_last | input | 1 | Marks src_data as the final byte |
| src_valid | input | 1 | Source offers a byte |
| src_ready | output | 1 | Block accepts a byte this cycle |
| tgt_prog_n | output | 1 | Target program/reset line, active low |
| tgt_init | input | 1 | Target init line, high when ready for data |
| tgt_done | input | 1 | Target done line |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_dout | output | 1 | Serial configuration data |
| busy | output | 1 | Run in progress |
| cfg_ok | output | 1 | Run finished with start-up clocks issued |
| err_init | output | 1 | Init timeout |
| err_done | output | 1 | Done timeout |

## Verification
Two events can land on the same cycle. One is the falling edge that would end the padding phase on timeout. The other is the first sampling of a freshly risen done. The case is provoked by raising done right after padding edge number PAD_LIMIT, and again one edge later. The first placement must yield cfg_ok after PAD_LIMIT+8 post-data edges. The second must yield err_done after exactly PAD_LIMIT.

A second overlap is done rising while data bits are still being shifted. Here the rising-edge count must still cover every data bit plus eight. A sweep over all 256 single-byte values, with done placed over a range of edges and source stalls toggled, checks each bit against the byte computed in the bench.

// File: rtl/serial_cfg_loader_pkg.sv
package serial_cfg_loader_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WINIT,
        ST_LOAD,
        ST_SHIFT,
        ST_PAD,
        ST_POST,
        ST_OK,
        ST_EINIT,
        ST_EDONE
    } ld_state_t;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } ld_byte_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_parked(input ld_state_t s);
        return (s == ST_IDLE) || (s == ST_OK) || (s == ST_EINIT) || (s == ST_EDONE);
    endfunction

    function automatic logic clk_runs(input ld_state_t s);
        return (s == ST_SHIFT) || (s == ST_PAD) || (s == ST_POST);
    endfunction

endpackage

// File: rtl/cfgld_clkdiv.sv
module cfgld_clkdiv #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic cfg_clk,
    output logic rise,
    output logic fall
);
    localparam int unsigned DW = $clog2(HALF) + 1;
    localparam logic [DW-1:0] TOP = DW'(HALF - 1);

    logic [DW-1:0] div_cnt;
    logic          tick;

    assign tick = run && (div_cnt == TOP);
    assign rise = tick && !cfg_clk;
    assign fall = tick && cfg_clk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
            cfg_clk <= 1'b0;
        end else if (tick) begin
            div_cnt <= '0;
            cfg_clk <= ~cfg_clk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R3: a clock edge only ever follows a cycle in which running was requested
    p_rise_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_clk) |-> $past(run));

endmodule

// File: rtl/cfgld_shreg.sv
module cfgld_shreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    input  logic         din_last,
    output logic         msb,
    output logic         at_last_bit,
    output logic         is_last_byte
);
    localparam int unsigned IW = $clog2(W);

    logic [W-1:0]  sr;
    logic [IW-1:0] idx;
    logic          last_q;

    assign msb          = sr[W-1];
    assign at_last_bit  = (idx == IW'(W - 1));
    assign is_last_byte = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '1;
            idx    <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            sr     <= din;
            idx    <= '0;
            last_q <= din_last;
        end else if (shift) begin
            sr     <= {sr[W-2:0], 1'b1};
            idx    <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/cfgld_count.sv
module cfgld_count #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import serial_cfg_loader_pkg::*;
#(
    parameter int unsigned CLK_DIV     = 4,
    parameter int unsigned PROG_CYCLES = 8,
    parameter int unsigned INIT_LIMIT  = 1000,
    parameter int unsigned PAD_LIMIT   = 2000,
    parameter int unsigned EXTRA_CLKS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_last,
    input  logic              src_valid,
    output logic              src_ready,
    output logic              tgt_prog_n,
    input  logic              tgt_init,
    input  logic              tgt_done,
    output logic              cfg_clk,
    output logic              cfg_dout,
    output logic              busy,
    output logic              cfg_ok,
    output logic              err_init,
    output logic              err_done
);
    // CLK_DIV must be even and at least 4
    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam int unsigned CMAX  = max2(max2(PROG_CYCLES, INIT_LIMIT), max2(PAD_LIMIT, EXTRA_CLKS));
    localparam int unsigned CNT_W = $clog2(CMAX + 1) + 1;
    localparam logic [CNT_W-1:0] PROG_END = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_LIMIT - 1);
    localparam logic [CNT_W-1:0] PAD_END  = CNT_W'(PAD_LIMIT);
    localparam logic [CNT_W-1:0] POST_END = CNT_W'(EXTRA_CLKS);

    ld_state_t        st, st_n;
    ld_byte_t         word;
    logic             run, rise, fall;
    logic             sh_load, sh_shift, sh_msb, sh_at_last, sh_last_byte;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;

    assign word = '{last: src_last, data: src_data};
    assign run  = clk_runs(st);

    cfgld_clkdiv #(.HALF(HALF)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .cfg_clk (cfg_clk),
        .rise    (rise),
        .fall    (fall)
    );

    cfgld_shreg #(.W(BYTE_W)) u_shift (
        .clk          (clk),
        .rst          (rst),
        .load         (sh_load),
        .shift        (sh_shift),
        .din          (word.data),
        .din_last     (word.last),
        .msb          (sh_msb),
        .at_last_bit  (sh_at_last),
        .is_last_byte (sh_last_byte)
    );

    // one counter serves every phase: system cycles early on, clock rises later
    assign cnt_clr = (st_n != st);
    assign cnt_inc = (st == ST_PROG) || (st == ST_WINIT) ||
                     (((st == ST_PAD) || (st == ST_POST)) && rise);

    cfgld_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .value (cnt)
    );

    always_comb begin
        st_n     = st;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        case (st)
            ST_IDLE, ST_OK, ST_EINIT, ST_EDONE: begin
                if (start) st_n = ST_PROG;
            end
            ST_PROG: begin
                if (cnt == PROG_END) st_n = ST_WINIT;
            end
            ST_WINIT: begin
                if (tgt_init)             st_n = ST_LOAD;
                else if (cnt == INIT_END) st_n = ST_EINIT;
            end
            ST_LOAD: begin
                if (src_valid) begin
                    sh_load = 1'b1;
                    st_n    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                // done is deliberately not examined while data is moving
                if (fall) begin
                    if (sh_at_last) st_n = sh_last_byte ? ST_PAD : ST_LOAD;
                    else            sh_shift = 1'b1;
                end
            end
            ST_PAD: begin
                if (tgt_done)                   st_n = ST_POST;
                else if (fall && cnt == PAD_END) st_n = ST_EDONE;
            end
            ST_POST: begin
                if (fall && cnt == POST_END) st_n = ST_OK;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    assign src_ready  = (st == ST_LOAD);
    assign tgt_prog_n = (st != ST_PROG);
    assign cfg_dout   = ((st == ST_LOAD) || (st == ST_SHIFT)) ? sh_msb : 1'b1;
    assign busy       = !is_parked(st);
    assign cfg_ok     = (st == ST_OK);
    assign err_init   = (st == ST_EINIT);
    assign err_done   = (st == ST_EDONE);

    // R3: clock parked low whenever the sequencer is not in a clocking phase
    p_clk_parked_r3: assert property (@(posedge clk) disable iff (rst)
        !run |-> !cfg_clk);

    // R4: data is steady across every rising edge and the whole high phase
    p_dout_steady_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_clk |-> $stable(cfg_dout));

    // R5: a byte is requested only with the clock low
    p_ready_low_clk_r5: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> !cfg_clk);

    // R6: shifting never jumps straight to the post-done phase
    p_no_early_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT) |=> (st == ST_SHIFT || st == ST_LOAD || st == ST_PAD));

    // R8: success follows the last counted start-up clock
    p_ok_after_extra_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_ok) |-> ($past(cnt) == POST_END));

    // R9: done timeout only after the full padding allowance
    p_pad_timeout_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_done) |-> ($past(cnt) == PAD_END));

    // R10: no outcome flag while busy
    p_flags_idle_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(cfg_ok || err_init || err_done));

endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;

    localparam int CLK_DIV = 4;
    localparam int PROG_C  = 3;
    localparam int INIT_L  = 12;
    localparam int PAD_L   = 6;
    localparam int EXTRA   = 8;
    localparam int RUN_MAX = 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_last = 1'b0;
    logic       src_valid = 1'b0;
    logic       src_ready;
    logic       tgt_prog_n;
    logic       tgt_init = 1'b0;
    logic       tgt_done = 1'b0;
    logic       cfg_clk, cfg_dout, busy, cfg_ok, err_init, err_done;

    logic [7:0] bytes [0:7];
    int n_checks = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    serial_cfg_loader #(
        .CLK_DIV(CLK_DIV), .PROG_CYCLES(PROG_C), .INIT_LIMIT(INIT_L),
        .PAD_LIMIT(PAD_L), .EXTRA_CLKS(EXTRA)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .src_data(src_data),
        .src_last(src_last), .src_valid(src_valid), .src_ready(src_ready),
        .tgt_prog_n(tgt_prog_n), .tgt_init(tgt_init), .tgt_done(tgt_done),
        .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .busy(busy), .cfg_ok(cfg_ok),
        .err_init(err_init), .err_done(err_done)
    );

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cfg(input int nb, input int done_at, input int init_delay,
                           input bit stall, input bit poke);
        int rises = 0, hi_len = 0, since = 0, prog_low = 0, idx = 0, cyc = 0, k = 0;
        int bit_err = 0, pad_err = 0, hi_err = 0, dout_err = 0, rdy_err = 0, busy_err = 0;
        int late = 0, exp_rises;
        bit prev_clk, prev_dout, released = 0, seen_low = 0, finished = 0;
        bit exp_ok, exp_ei, exp_ed;

        exp_ei = (init_delay < 0);
        exp_ok = !exp_ei && (done_at <= 8 * nb + PAD_L);
        exp_ed = !exp_ei && !exp_ok;
        if (exp_ei)      exp_rises = 0;
        else if (exp_ok) exp_rises = ((done_at > 8 * nb) ? done_at : 8 * nb) + EXTRA;
        else             exp_rises = 8 * nb + PAD_L;

        tgt_done = 1'b0; tgt_init = 1'b0; src_valid = 1'b0; src_last = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        prev_clk = cfg_clk; prev_dout = cfg_dout;
        while (!finished && cyc < RUN_MAX) begin
            if (!tgt_prog_n) begin prog_low++; seen_low = 1'b1; end
            else if (seen_low) released = 1'b1;
            if (released) since++;
            if (cfg_clk && !prev_clk) begin
                rises++;
                k = rises - 1;
                if (k < 8 * nb) begin
                    if (cfg_dout !== bytes[k / 8][7 - (k % 8)]) bit_err++;
                end else if (cfg_dout !== 1'b1) pad_err++;
            end
            if (cfg_clk) hi_len++;
            else begin
                if (prev_clk && hi_len != CLK_DIV / 2) hi_err++;
                hi_len = 0;
            end
            if (cfg_clk && (cfg_dout !== prev_dout)) dout_err++;
            if (src_ready && cfg_clk) rdy_err++;
            if (cyc == 0 && !busy) busy_err++;
            if (busy && (cfg_ok || err_init || err_done)) busy_err++;
            if (!busy) finished = 1'b1;
            prev_clk = cfg_clk; prev_dout = cfg_dout;

            tgt_done = (rises >= done_at);
            tgt_init = (init_delay >= 0) && released && (since >= init_delay);
            start    = poke && (cyc == 20);
            if (idx < nb && !(stall && (cyc % 5) < 2)) begin
                src_valid = 1'b1; src_data = bytes[idx]; src_last = (idx == nb - 1);
            end else begin
                src_valid = 1'b0; src_last = 1'b0;
            end
            if (src_valid && src_ready) idx++;
            cyc++;
            if (!finished) @(negedge clk);
        end
        start = 1'b0; src_valid = 1'b0;

        chk(cyc < RUN_MAX, "watchdog", cyc, RUN_MAX);
        chk(prog_low == PROG_C, "R2 program pulse width", prog_low, PROG_C);
        chk(busy_err == 0, poke ? "R10 busy with restart attempt" : "R10 busy span", busy_err, 0);
        chk(hi_err == 0, "R3 high phase length", hi_err, 0);
        chk(dout_err == 0, "R4 data moved with clock high", dout_err, 0);
        chk(bit_err == 0, (done_at <= 8 * nb) ? "R6 bits with early done" : "R4 msb-first bits",
            bit_err, 0);
        chk(pad_err == 0, "R7 padding ones", pad_err, 0);
        chk(rdy_err == 0, "R5 ready with clock high", rdy_err, 0);
        chk(idx == (exp_ei ? 0 : nb), "R5 bytes taken", idx, exp_ei ? 0 : nb);
        chk(rises == exp_rises,
            exp_ok ? "R8 clock count" : (exp_ei ? "R2 no clock on init timeout" : "R9 clock count"),
            rises, exp_rises);
        chk(cfg_ok == exp_ok, "R8 success flag", cfg_ok, exp_ok);
        chk(err_done == exp_ed, "R9 done timeout flag", err_done, exp_ed);
        chk(err_init == exp_ei, "R2 init timeout flag", err_init, exp_ei);
        for (int i = 0; i < 2 * CLK_DIV; i++) begin
            @(negedge clk);
            if (cfg_clk) late++;
        end
        chk(late == 0, "R8 clock parked after finish", late, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !cfg_ok && !err_init && !err_done, "R1 flags after reset",
            {busy, cfg_ok, err_init, err_done}, 0);
        chk(!cfg_clk && !src_ready, "R1 clock and ready after reset", {cfg_clk, src_ready}, 0);
        chk(tgt_prog_n && cfg_dout, "R1 prog and data idle high", {tgt_prog_n, cfg_dout}, 3);

        bytes[0] = 8'hA5;
        run_cfg(1, 3, 2, 1'b0, 1'b0);             // R6: done during data
        bytes[0] = 8'h3C; bytes[1] = 8'h81; bytes[2] = 8'hF0;
        run_cfg(3, 28, 4, 1'b1, 1'b1);            // R5 stalls, R10 restart ignored
        bytes[0] = 8'h01; bytes[1] = 8'hFE;
        run_cfg(2, 16 + PAD_L, 1, 1'b0, 1'b0);    // R9 boundary: done just in time
        run_cfg(2, 16 + PAD_L + 1, 1, 1'b0, 1'b0); // R9: one edge late
        run_cfg(1, 5, -1, 1'b0, 1'b0);            // R2: init never rises

        for (int v = 0; v < 256; v++) begin
            bytes[0] = 8'(v);
            run_cfg(1, 1 + (v % 16), v % 3, v[0], 1'b0);
        end
        for (int n = 2; n <= 8; n++) begin
            for (int i = 0; i < n; i++) bytes[i] = 8'((n * 29 + i * 83 + 7) % 256);
            run_cfg(n, 8 * n + (n % 3), 2, n[0], 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule